// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block carries 8-bit PCM samples between a parallel sample interface and a time-division-multiplexed serial bus. All of its sequential logic runs from the serial bit clock. The transmit direction and the receive direction each have their own frame sync input and their own slot timer. A parallel transmit byte is captured when the outgoing slot opens and is sent MSB first. A received byte is assembled from the serial input and handed over with a single-cycle valid strobe.

A small configuration register holds three settings, written through a load strobe: the timing mode, the assigned slot number and the selected bus port. In non-delayed mode, the rising edge of a frame sync opens the slot immediately and the slot number plays no part. In delayed mode, the frame sync marks the start of the frame. A bit counter then places slot N so that it starts 8N+1 bit periods after the sync edge. Each port has a serial output with an output enable, and an open-drain style slot strobe for a backplane line driver. The strobe is modelled as a pull-low enable.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is asserted and right after it, every serial output enable and slot strobe is 0 and rx_valid is 0. The configuration resets to non-delayed mode (mode code 0), slot 0, port 0.
- R2: In non-delayed mode (mode code 0), the transmit slot opens at the first rising bit_clk edge where tx_sync is seen high after being low, whatever the slot setting. From that edge onward, on each of 8 rising edges, the port drives the next bit of the byte, MSB first.
- R3: In delayed mode (mode code 1), with slot number N, the slot opens on the rising edge that comes 8N+1 edges after the edge where the frame sync was first seen high.
- R4: A slot keeps its output enable high for exactly 8 consecutive bit periods. The enable is raised only on the port whose index equals the port setting, and at most one port is enabled at any time.
- R5: The slot strobe of each port is high exactly when that port's serial output is enabled.
- R6: During the receive slot, ser_in of the selected port is sampled on each falling bit_clk edge, MSB first. The ser_in lines of the other ports do not affect rx_data.
- R7: rx_valid pulses high for exactly one bit period. It starts on the rising edge that ends the eighth receive bit period, and rx_data then holds the assembled byte.
- R8: tx_data is captured on the edge that opens the slot. Changes to tx_data after that edge do not alter the bits sent in that slot.
- R9: Receive timing follows rx_sync only and transmit timing follows tx_sync only, so the two slots may be offset from each other.
- R10: Mode, slot and port change only on a rising edge where cfg_we is high. Values on the cfg inputs at other times are ignored.
- R11: A frame sync held high for many bit periods opens only one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the configuration register |
| cfg_mode | input | 1 | Timing mode: 0 non-delayed, 1 delayed |
| cfg_slot | input | SLOT_W (6) | Assigned slot number |
| cfg_port | input | PORT_W (1) | Selected bus port |
| tx_sync | input | 1 | Transmit frame sync |
| rx_sync | input | 1 | Receive frame sync |
| tx_data | input | 8 | Parallel byte to transmit |
| ser_out | output | NPORT (2) | Serial transmit data per port (0 when not enabled) |
| ser_out_en | output | NPORT (2) | Tri-state enable per port |
| slot_pull | output | NPORT (2) | Slot strobe pull-low enable per port |
| ser_in | input | NPORT (2) | Serial receive data per port |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |

## Verification
The assertions assume three things about the inputs. Consecutive slots on one direction start at least eight bit periods apart. The configuration does not change while a slot is open. Each frame sync is a clean level, stable across each rising edge. The stimulus gives every frame sync only a single one-period pulse or one long hold. It writes the configuration only after an idle stretch longer than a full 512-bit frame, so the delayed-mode counter has run out before any setting changes. It changes ser_in and the syncs just after rising edges, so each falling-edge sample sees a settled bit.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  localparam int SLOT_BITS = 8;
  localparam int IDX_W = $clog2(SLOT_BITS);

  typedef enum logic {
    TM_AT_SLOT   = 1'b0,
    TM_AT_FRAME  = 1'b1
  } timing_mode_e;

  // first bit period of a slot, counted from the first bit after the sync
  function automatic int unsigned slot_first_bit(input int unsigned slot);
    return slot * SLOT_BITS;
  endfunction

  // index of the final bit of a slot
  function automatic logic [IDX_W-1:0] last_idx();
    return IDX_W'(SLOT_BITS - 1);
  endfunction
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int MAX_BITS = 512,
  parameter int SLOT_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fs,
  input  logic                            dly,
  input  logic [SLOT_W-1:0]               slot,
  output logic                            start,
  output logic                            act,
  output logic [pcm_tdm_pkg::IDX_W-1:0]   idx
);
  import pcm_tdm_pkg::*;
  localparam int FCNT_W = $clog2(MAX_BITS);

  logic              fs_q;
  logic              fs_rise;
  logic              armed;
  logic              hit;
  logic [FCNT_W-1:0] fcnt;

  always_comb begin
    fs_rise = fs & ~fs_q;
    hit     = armed && !fs_rise &&
              (fcnt == FCNT_W'(slot_first_bit(32'(slot))));
    start   = dly ? hit : fs_rise;
  end

  // frame bit counter, only meaningful in delayed mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b0;
      armed <= 1'b0;
      fcnt  <= '0;
    end else begin
      fs_q <= fs;
      if (fs_rise) begin
        armed <= 1'b1;
        fcnt  <= '0;
      end else if (armed) begin
        if (fcnt == FCNT_W'(MAX_BITS - 1)) armed <= 1'b0;
        else fcnt <= fcnt + 1'b1;
      end
    end
  end

  // slot window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
    end else if (start) begin
      act <= 1'b1;
      idx <= '0;
    end else if (act) begin
      idx <= idx + 1'b1;
      if (idx == last_idx()) act <= 1'b0;
    end
  end

  assert_slot_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && idx != last_idx()) |=> act);

  assert_at_slot_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(act) && !$past(dly)) |-> $past(fs));

  assert_at_frame_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(act) && $past(dly)) |-> !$past(fs_rise));
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [pcm_tdm_pkg::IDX_W-1:0]        idx,
  input  logic [pcm_tdm_pkg::SLOT_BITS-1:0]    load_data,
  output logic                                 bit_o
);
  import pcm_tdm_pkg::*;
  logic [SLOT_BITS-1:0] hold;

  // byte is frozen on the opening edge; the bit index walks MSB to LSB
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else if (start) hold <= load_data;
  end

  assign bit_o = hold[last_idx() - idx];
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 act,
  input  logic [pcm_tdm_pkg::IDX_W-1:0]        idx,
  input  logic                                 din,
  output logic [pcm_tdm_pkg::SLOT_BITS-1:0]    data,
  output logic                                 valid
);
  import pcm_tdm_pkg::*;
  logic [SLOT_BITS-1:0] sh;
  logic [SLOT_BITS-1:0] hold;
  logic                 tgl;
  logic                 tgl_q;
  logic                 done_evt;

  // capture on falling edges inside the window
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      hold <= '0;
      tgl  <= 1'b0;
    end else if (act) begin
      sh <= {sh[SLOT_BITS-2:0], din};
      if (idx == last_idx()) begin
        hold <= {sh[SLOT_BITS-2:0], din};
        tgl  <= ~tgl;
      end
    end
  end

  assign done_evt = tgl ^ tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      tgl_q <= tgl;
      valid <= done_evt;
      if (done_evt) data <= hold;
    end
  end

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_rx_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act && idx == '0));
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int NPORT    = 2,
  parameter int MAX_BITS = 512,
  localparam int SLOT_W  = $clog2(MAX_BITS) - 3,
  localparam int PORT_W  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_mode,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic                 tx_sync,
  input  logic                 rx_sync,
  input  logic [7:0]           tx_data,
  output logic [NPORT-1:0]     ser_out,
  output logic [NPORT-1:0]     ser_out_en,
  output logic [NPORT-1:0]     slot_pull,
  input  logic [NPORT-1:0]     ser_in,
  output logic [7:0]           rx_data,
  output logic                 rx_valid
);
  import pcm_tdm_pkg::*;

  timing_mode_e        mode_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [PORT_W-1:0]   port_q;

  logic                tx_start, tx_act, tx_bit;
  logic [IDX_W-1:0]    tx_idx;
  logic                rx_start, rx_act, rx_din;
  logic [IDX_W-1:0]    rx_idx;
  logic                dly;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TM_AT_SLOT;
      slot_q <= '0;
      port_q <= '0;
    end else if (cfg_we) begin
      mode_q <= timing_mode_e'(cfg_mode);
      slot_q <= cfg_slot;
      port_q <= cfg_port;
    end
  end

  assign dly = (mode_q == TM_AT_FRAME);

  pcm_slot_timer #(.MAX_BITS(MAX_BITS), .SLOT_W(SLOT_W)) u_tx_tmr (
    .clk(bit_clk), .rst_n(rst_n), .fs(tx_sync), .dly(dly), .slot(slot_q),
    .start(tx_start), .act(tx_act), .idx(tx_idx));

  pcm_slot_timer #(.MAX_BITS(MAX_BITS), .SLOT_W(SLOT_W)) u_rx_tmr (
    .clk(bit_clk), .rst_n(rst_n), .fs(rx_sync), .dly(dly), .slot(slot_q),
    .start(rx_start), .act(rx_act), .idx(rx_idx));

  pcm_tx_shift u_tx (
    .clk(bit_clk), .rst_n(rst_n), .start(tx_start), .idx(tx_idx),
    .load_data(tx_data), .bit_o(tx_bit));

  assign rx_din = ser_in[port_q];

  pcm_rx_shift u_rx (
    .clk(bit_clk), .rst_n(rst_n), .start(rx_start), .act(rx_act), .idx(rx_idx),
    .din(rx_din), .data(rx_data), .valid(rx_valid));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign ser_out_en[p] = tx_act && (port_q == PORT_W'(p));
    assign slot_pull[p]  = ser_out_en[p];
    assign ser_out[p]    = ser_out_en[p] & tx_bit;
  end

  assert_one_port_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $onehot0(ser_out_en));

  assert_cfg_hold_R10: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !$past(cfg_we) |-> ($stable(mode_q) && $stable(slot_q) && $stable(port_q)));
endmodule

// File: tb/sim_pcm_tdm_port.sv
module sim_pcm_tdm_port;
  localparam int BCLK_PERIOD = 20;
  localparam int NP = 2;
  localparam int SW = 6;
  localparam int PW = 1;
  localparam int NV = 6;
  // {mode, slot[5:0], port, rx_offset[3:0], tx_byte, rx_byte}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 6'd5,  1'b0, 4'd0, 8'hA5, 8'h3C},
    {1'b0, 6'd0,  1'b1, 4'd3, 8'h81, 8'h7E},
    {1'b1, 6'd0,  1'b0, 4'd0, 8'hC3, 8'h5A},
    {1'b1, 6'd3,  1'b1, 4'd2, 8'h96, 8'hE1},
    {1'b1, 6'd1,  1'b0, 4'd0, 8'h00, 8'hFF},
    {1'b1, 6'd63, 1'b1, 4'd0, 8'hFF, 8'h01}
  };

  logic bit_clk = 1'b0;
  logic rst_n, cfg_we, cfg_mode, tx_sync, rx_sync, rx_valid;
  logic [SW-1:0] cfg_slot;
  logic [PW-1:0] cfg_port;
  logic [7:0] tx_data, rx_data;
  logic [NP-1:0] ser_out, ser_out_en, slot_pull, ser_in;
  int n_chk = 0;
  int n_fail = 0;

  pcm_tdm_port #(.NPORT(NP), .MAX_BITS(512)) u0 (
    .bit_clk(bit_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_slot(cfg_slot), .cfg_port(cfg_port), .tx_sync(tx_sync), .rx_sync(rx_sync),
    .tx_data(tx_data), .ser_out(ser_out), .ser_out_en(ser_out_en),
    .slot_pull(slot_pull), .ser_in(ser_in), .rx_data(rx_data), .rx_valid(rx_valid));

  always #(BCLK_PERIOD/2) bit_clk = ~bit_clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick;
    @(posedge bit_clk);
    #2;
  endtask

  task automatic write_cfg(input bit m, input int s, input int p);
    cfg_we = 1'b1; cfg_mode = m; cfg_slot = SW'(s); cfg_port = PW'(p);
    tick;
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) tick;
    check(ser_out_en == '0 && slot_pull == '0, "R4 idle", {30'd0, ser_out_en}, 0);
  endtask

  // one tx slot and one rx slot; syncs pulse for one bit period
  task automatic run_slot(input bit dly, input int slot, input int port, input int roff,
                          input logic [7:0] tb, input logic [7:0] rb);
    int d, rd, last, j;
    logic [NP-1:0] exp_en;
    d = dly ? 1 + 8 * slot : 0;
    rd = roff + d;
    last = ((rd > d) ? rd : d) + 8;
    tx_data = tb;
    tx_sync = 1'b1;
    rx_sync = (roff == 0);
    for (int t = 0; t <= last; t++) begin
      tick;
      exp_en = (t >= d && t < d + 8) ? NP'(1 << port) : '0;
      check(ser_out_en == exp_en, "R4", {30'd0, ser_out_en}, {30'd0, exp_en});
      check(slot_pull == exp_en, "R5", {30'd0, slot_pull}, {30'd0, exp_en});
      if (exp_en != '0) begin
        j = t - d;
        // R8: tx_data was changed after the opening edge; original bits expected
        check(ser_out[port] == tb[7-j], dly ? "R3 R8" : "R2 R8", {31'd0, ser_out[port]}, {31'd0, tb[7-j]});
      end
      check(rx_valid == (t == rd + 8), "R7 valid", {31'd0, rx_valid}, {31'd0, t == rd + 8});
      if (t == rd + 8) check(rx_data == rb, "R6 R9 data", {24'd0, rx_data}, {24'd0, rb});
      tx_sync = 1'b0;
      if (t == d) tx_data = ~tb;
      rx_sync = (t + 1 == roff);
      if (t >= rd && t < rd + 8) begin
        ser_in[port] = rb[7-(t-rd)];
        ser_in[1-port] = ~rb[7-(t-rd)];
      end else begin
        ser_in = '0;
      end
    end
  endtask

  initial begin
    #(BCLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    summary;
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 1'b0; cfg_slot = '0; cfg_port = '0;
    tx_sync = 1'b0; rx_sync = 1'b0; tx_data = '0; ser_in = '0;
    repeat (3) tick;
    check(ser_out_en == '0 && slot_pull == '0, "R1 in reset", {30'd0, ser_out_en}, 0);
    check(rx_valid == 1'b0, "R1 in reset", {31'd0, rx_valid}, 0);
    rst_n = 1'b1;
    tick;
    check(ser_out_en == '0 && rx_valid == 1'b0, "R1 after reset", {30'd0, ser_out_en}, 0);
    // R1: default configuration is non-delayed on port 0
    run_slot(1'b0, 0, 0, 0, 8'h5A, 8'hC3);

    for (int i = 0; i < NV; i++) begin
      idle(520);
      write_cfg(VEC[i][27], int'(VEC[i][26:21]), int'(VEC[i][20]));
      run_slot(VEC[i][27], int'(VEC[i][26:21]), int'(VEC[i][20]), int'(VEC[i][19:16]),
               VEC[i][15:8], VEC[i][7:0]);
    end

    // R10: cfg inputs without cfg_we are ignored
    idle(520);
    write_cfg(1'b0, 0, 0);
    cfg_mode = 1'b1; cfg_slot = SW'(2); cfg_port = PW'(1);
    tick;
    run_slot(1'b0, 0, 0, 0, 8'h3E, 8'h92);

    // R11: a held frame sync opens a single slot
    idle(20);
    tx_data = 8'hF0;
    tx_sync = 1'b1;
    for (int t = 0; t < 20; t++) begin
      tick;
      check(ser_out_en == ((t < 8) ? 2'b01 : 2'b00), "R11", {30'd0, ser_out_en}, (t < 8) ? 1 : 0);
    end
    tx_sync = 1'b0;
    idle(4);

    summary;
    $finish;
  end
endmodule